// File: doc/BRIEF.md
# Digital audio lock and status qualifier

This block sits between the clock-recovery loop, the serial audio frame decoder and the audio datapath. It turns two raw lock flags and the decoded channel-status bits into one qualified lock, a hard-mute request and an automatic de-emphasis selection. It also produces a packed status byte that a control port can read. The qualified lock goes high only after a programmable number of consecutive good audio blocks. It drops in the same cycle that either loop loses lock. It also drops right after a block that carries non-PCM content.

Channel-status fields are sampled at audio block boundaries only, so every field in the status byte comes from one block. A one-cycle strobe from the decoder marks each boundary. The hard-mute request forces the audio to zero while the qualified lock is absent, and an enable input can switch this off.

Top module: `audio_lock_qual`

## Requirements
- R1: `lock_o` is 1 only while `pll_lock_i` is 1, `dec_lock_i` is 1 and the most recent block boundary reported PCM content (`cs_nonpcm_i`=0); otherwise it is 0.
- R2: With both loops locked, `lock_o` rises in the cycle after the block-boundary strobe that completes N consecutive good blocks. N is `qual_blocks_i`, and a value of 0 acts as 1. Earlier boundaries leave it low.
- R3: When `pll_lock_i` or `dec_lock_i` goes to 0, `lock_o` falls in the same cycle with no register delay, and the good-block count restarts from zero.
- R4: A block-boundary strobe with `cs_nonpcm_i`=1 clears `lock_o` from the next cycle and restarts the good-block count, even while both loops stay locked.
- R5: `hard_mute_o` is 1 exactly when `auto_mute_en_i` is 1 and `lock_o` is 0.
- R6: While `auto_mute_en_i` is 0, `hard_mute_o` stays 0 whatever the lock state.
- R7: The latched channel-status fields take new values only at a block-boundary strobe that arrives while `dec_lock_i` is 1. They keep their value between strobes.
- R8: `status_o` bit layout: [0] live PLL lock, [1] `lock_o`, [3:2] sample rate (00 = 44.1 kHz, 01 = undefined, 10 = 48 kHz, 11 = 32 kHz), [4] non-PCM flag (0 = two-channel PCM), [5] pre-emphasis flag, [7:6] clock accuracy (00 = level II, 01 = level I, 10 = level III, 11 = undefined).
- R9: `deemph_o` is 01 for 32 kHz, 10 for 44.1 kHz and 11 for 48 kHz when the latched pre-emphasis flag is 1. It is 00 when the flag is 0 or the latched rate is undefined.
- R10: After reset the latched rate is 01, the accuracy is 11, the non-PCM flag is 1, the pre-emphasis flag is 0 and `lock_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pll_lock_i | input | 1 | Clock-recovery lock |
| dec_lock_i | input | 1 | Frame decoder lock |
| blk_end_i | input | 1 | One-cycle strobe at each audio block boundary |
| cs_nonpcm_i | input | 1 | Channel status: 1 = not two-channel PCM |
| cs_preemph_i | input | 1 | Channel status: pre-emphasis flagged |
| cs_rate_i | input | 2 | Channel status: sample-rate code |
| cs_acc_i | input | 2 | Channel status: clock-accuracy code |
| auto_mute_en_i | input | 1 | Enables hard mute while unlocked |
| qual_blocks_i | input | CNT_W | Good blocks required before lock |
| lock_o | output | 1 | Qualified lock indication |
| hard_mute_o | output | 1 | Hard-mute request |
| deemph_o | output | 2 | De-emphasis select (00 off, 01 32k, 10 44.1k, 11 48k) |
| status_o | output | 8 | Packed status byte |

## Verification
On every cycle the assertions check four things. Any rise of the internal lock follows a good block-boundary strobe. A lost loop clears the lock register one cycle later. The latched fields hold steady between strobes. The qualified lock never coexists with a latched non-PCM flag, and a nonzero de-emphasis select never coexists with a clear pre-emphasis flag. Only the bench's scenarios can show the exact qualification count for several values of N, including N = 0. The same holds for the hard-mute bypass, the de-emphasis encoding for each rate and the same-cycle drop when a loop is lost. The bench compares every cycle with a bench-side model under random loop drops, non-PCM blocks and field values.

// File: rtl/aq_pkg.sv
package aq_pkg;
  typedef struct packed {
    logic [1:0] acc;
    logic       pre;
    logic       np;
    logic [1:0] rate;
  } cs_t;

  localparam logic [1:0] RATE_441   = 2'b00;
  localparam logic [1:0] RATE_UNDEF = 2'b01;
  localparam logic [1:0] RATE_48    = 2'b10;
  localparam logic [1:0] RATE_32    = 2'b11;

  localparam logic [1:0] DE_OFF = 2'b00;
  localparam logic [1:0] DE_32  = 2'b01;
  localparam logic [1:0] DE_441 = 2'b10;
  localparam logic [1:0] DE_48  = 2'b11;

  localparam logic [1:0] ACC_UNDEF = 2'b11;

  localparam cs_t CS_RESET = '{acc: ACC_UNDEF, pre: 1'b0, np: 1'b1, rate: RATE_UNDEF};
endpackage

// File: rtl/aq_lock_qual.sv
module aq_lock_qual #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pll_lock_i,
  input  logic             dec_lock_i,
  input  logic             blk_end_i,
  input  logic             nonpcm_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             lock_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_inc, need;
  logic             lock_q, loops_ok, good_blk;

  assign loops_ok = pll_lock_i & dec_lock_i;
  assign good_blk = blk_end_i & ~nonpcm_i;
  assign need     = (need_i == '0) ? CNT_ONE : need_i;
  assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!loops_ok || (blk_end_i && nonpcm_i)) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (good_blk) begin
      cnt_q <= cnt_inc;
      if (cnt_inc >= need) lock_q <= 1'b1;
    end
  end

  // deassertion must not wait for a clock edge
  assign lock_o = lock_q & loops_ok;

  assert_rise_on_good_block_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(good_blk && loops_ok));

  assert_loss_clears_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loops_ok |=> !lock_q);
endmodule

// File: rtl/aq_cs_latch.sv
module aq_cs_latch
  import aq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       blk_end_i,
  input  logic       dec_lock_i,
  input  cs_t        cs_i,
  output cs_t        cs_o,
  output logic [1:0] deemph_o
);
  cs_t cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cs_q <= CS_RESET;
    else if (blk_end_i && dec_lock_i) cs_q <= cs_i;
  end

  always_comb begin
    deemph_o = DE_OFF;
    if (cs_q.pre) begin
      unique case (cs_q.rate)
        RATE_32:  deemph_o = DE_32;
        RATE_441: deemph_o = DE_441;
        RATE_48:  deemph_o = DE_48;
        default:  deemph_o = DE_OFF;
      endcase
    end
  end

  assign cs_o = cs_q;

  assert_fields_hold_between_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(blk_end_i && dec_lock_i) |=> $stable(cs_q));
endmodule

// File: rtl/audio_lock_qual.sv
module audio_lock_qual
  import aq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pll_lock_i,
  input  logic             dec_lock_i,
  input  logic             blk_end_i,
  input  logic             cs_nonpcm_i,
  input  logic             cs_preemph_i,
  input  logic [1:0]       cs_rate_i,
  input  logic [1:0]       cs_acc_i,
  input  logic             auto_mute_en_i,
  input  logic [CNT_W-1:0] qual_blocks_i,
  output logic             lock_o,
  output logic             hard_mute_o,
  output logic [1:0]       deemph_o,
  output logic [7:0]       status_o
);
  logic lock;
  cs_t  cs_in, cs_lat;

  assign cs_in = '{acc: cs_acc_i, pre: cs_preemph_i, np: cs_nonpcm_i, rate: cs_rate_i};

  aq_lock_qual #(.CNT_W(CNT_W)) i_lock_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pll_lock_i (pll_lock_i),
    .dec_lock_i (dec_lock_i),
    .blk_end_i  (blk_end_i),
    .nonpcm_i   (cs_nonpcm_i),
    .need_i     (qual_blocks_i),
    .lock_o     (lock)
  );

  aq_cs_latch i_cs_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blk_end_i  (blk_end_i),
    .dec_lock_i (dec_lock_i),
    .cs_i       (cs_in),
    .cs_o       (cs_lat),
    .deemph_o   (deemph_o)
  );

  assign lock_o      = lock;
  assign hard_mute_o = auto_mute_en_i & ~lock;
  assign status_o    = {cs_lat, lock, pll_lock_i};

  assert_lock_implies_pcm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> !status_o[4]);

  assert_deemph_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deemph_o != DE_OFF) |-> status_o[5]);
endmodule

// File: tb/test_audio_lock_qual.sv
`timescale 1ns/1ps
module test_audio_lock_qual;
  localparam int CNT_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pll_lock_i = 0, dec_lock_i = 0, blk_end_i = 0, cs_nonpcm_i = 0, cs_preemph_i = 0;
  logic [1:0] cs_rate_i = 0, cs_acc_i = 0;
  logic auto_mute_en_i = 1;
  logic [CNT_W-1:0] qual_blocks_i = 0;
  logic lock_o, hard_mute_o;
  logic [1:0] deemph_o;
  logic [7:0] status_o;

  int n_tests = 0, n_fail = 0;

  // bench model state
  bit m_lock = 0;
  int m_cnt = 0;
  logic [1:0] m_rate = 2'b01, m_acc = 2'b11;
  bit m_np = 1, m_pre = 0;

  always #2 clk_i = ~clk_i;

  audio_lock_qual #(.CNT_W(CNT_W)) i_audio_lock_qual (
    .clk_i, .rst_ni, .pll_lock_i, .dec_lock_i, .blk_end_i, .cs_nonpcm_i, .cs_preemph_i,
    .cs_rate_i, .cs_acc_i, .auto_mute_en_i, .qual_blocks_i,
    .lock_o, .hard_mute_o, .deemph_o, .status_o
  );

  function automatic logic [1:0] exp_deemph(bit pre, logic [1:0] rate);
    if (!pre) return 2'b00;
    case (rate)
      2'b11: return 2'b01;
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic bit exp_lock();
    return m_lock && pll_lock_i && dec_lock_i;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit el;
    el = exp_lock();
    check("R1 lock", lock_o, el);
    if (auto_mute_en_i) check("R5 mute", hard_mute_o, !el);
    else                check("R6 mute bypass", hard_mute_o, 0);
    check("R8 status", status_o, {m_acc, m_pre, m_np, m_rate, el, pll_lock_i});
    check("R9 deemph", deemph_o, exp_deemph(m_pre, m_rate));
  endtask

  task automatic model_edge();
    int need;
    need = (qual_blocks_i == 0) ? 1 : qual_blocks_i;
    if (!pll_lock_i || !dec_lock_i || (blk_end_i && cs_nonpcm_i)) begin
      m_cnt = 0; m_lock = 0;
    end else if (blk_end_i) begin
      if (m_cnt < 15) m_cnt++;
      if (m_cnt >= need) m_lock = 1;
    end
    if (blk_end_i && dec_lock_i) begin
      m_rate = cs_rate_i; m_acc = cs_acc_i; m_np = cs_nonpcm_i; m_pre = cs_preemph_i;
    end
  endtask

  // drive at negedge, check after settle, then advance the model past the next edge
  task automatic step(bit pll, bit dec, bit blk, bit np, bit pre, logic [1:0] rate,
                      logic [1:0] acc);
    @(negedge clk_i);
    pll_lock_i = pll; dec_lock_i = dec; blk_end_i = blk; cs_nonpcm_i = np;
    cs_preemph_i = pre; cs_rate_i = rate; cs_acc_i = acc;
    #1 check_all();
    model_edge();
  endtask

  task automatic good_block(bit pre, logic [1:0] rate);
    step(1, 1, 1, 0, pre, rate, 2'b01);
    step(1, 1, 0, 0, 0, 2'b00, 2'b00);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    check("R10 reset lock", lock_o, 0);
    check("R10 reset status", status_o, 8'hD4);
    check("R10 reset deemph", deemph_o, 0);
    rst_ni = 1;

    // R2: three blocks required
    qual_blocks_i = 3;
    step(1, 1, 0, 0, 0, 2'b00, 2'b00);
    good_block(1, 2'b11);
    good_block(1, 2'b11);
    check("R2 not yet locked", lock_o, 0);
    good_block(1, 2'b11);
    check("R2 locked after 3", lock_o, 1);
    check("R9 deemph 32k", deemph_o, 2'b01);

    // R3: same-cycle drop
    @(negedge clk_i); pll_lock_i = 0; #1;
    check("R3 immediate drop", lock_o, 0);
    model_edge();
    step(1, 1, 0, 0, 0, 2'b00, 2'b00);
    check("R3 count restarted", lock_o, 0);

    // R2: zero acts as one
    qual_blocks_i = 0;
    good_block(0, 2'b00);
    check("R2 N=0 locks after one block", lock_o, 1);

    // R4: non-PCM block with loops locked
    step(1, 1, 1, 1, 1, 2'b10, 2'b10);
    step(1, 1, 0, 0, 0, 2'b00, 2'b00);
    check("R4 non-PCM drops lock", lock_o, 0);
    check("R8 non-PCM bit", status_o[4], 1);

    // R7: strobe without decoder lock is ignored
    good_block(1, 2'b10);
    step(1, 0, 1, 0, 0, 2'b11, 2'b11);
    step(1, 1, 0, 0, 0, 2'b00, 2'b00);
    check("R7 fields kept", status_o[7:2], {2'b01, 1'b1, 1'b0, 2'b10});
    check("R9 deemph 48k", deemph_o, 2'b11);

    // R6: mute bypass
    auto_mute_en_i = 0;
    step(0, 1, 0, 0, 0, 2'b00, 2'b00);
    check("R6 no mute while unlocked", hard_mute_o, 0);
    auto_mute_en_i = 1;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) qual_blocks_i = CNT_W'($urandom_range(0, 6));
      if (i % 97 == 0)  auto_mute_en_i = ($urandom_range(0, 3) != 0);
      step(($urandom_range(0, 40) != 0), ($urandom_range(0, 40) != 0),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 12) == 0),
           $urandom_range(0, 1), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule